// File: doc/BRIEF.md
# Two-Wire EEPROM Sequential Byte Reader

This block reads a run of consecutive bytes out of a two-wire serial EEPROM. It drives the bus clock, the data value and a data output enable itself. The data line is open-drain: when the enable is low the pull-up holds it high, or the memory pulls it low.

A single start strobe launches a random read. The strobe carries a base word address and a byte count. The block then performs these steps in order:

1. A start condition.
2. The write control byte, as a dummy write.
3. The word address.
4. A repeated start.
5. The read control byte.
6. The requested number of data bytes.
7. A stop condition.

All bytes travel most significant bit first. Each clock half-period lasts a parameterised number of system clocks.

Each received byte is presented with a one-cycle valid strobe. A one-cycle done pulse closes every transaction. An error flag reports a transmitted byte that the memory did not acknowledge. A typical use is to fetch a six-byte station address from a fixed word address such as 0x83, 0x99, 0xAF or 0xF8.

Top module: `eeprom_rd_seq`

## Requirements
- R1: The data output and its enable never change in the same system cycle as an edge of the bus clock, so the bus data changes only while the clock is low, except for start and stop.
- R2: A start or repeated start is made by the data line falling while the clock is high with the output enabled. Each successful transaction contains exactly two of them.
- R3: A stop is made by the data line rising while the clock is high, and ends with the clock low and the output disabled. After reset the bus is idle: clock low, enable low, data output high.
- R4: The bytes sent on the bus are 0xA0 (device select 0x50, write bit 0), then the base address, then 0xA1 (read bit 1). Read bytes are assembled most significant bit first.
- R5: Every high phase of the bus clock lasts HALF_CYC system cycles. Start and stop hold it high for two half-periods.
- R6: After each received byte except the last, the block drives a low acknowledge bit. After the last byte it leaves the data line high.
- R7: Each received byte appears on rdByte together with a single-cycle rdValid pulse. Exactly byteCount such pulses occur per transaction, and the k-th byte is the memory content at base+k (modulo 256).
- R8: A high acknowledge after any of the three transmitted bytes makes the block issue a stop without reading data. It then ends with done and ackErr both high.
- R9: done is a one-cycle pulse at the end of every accepted transaction. ackErr rises only together with done, stays low after a clean transaction, and is cleared when the next start is accepted.
- R10: A start strobe while a transaction is in progress is ignored. A start strobe with byteCount of zero is ignored: there is no bus activity and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request to begin a read |
| baseAddr | input | 8 | First word address to read |
| byteCount | input | CNT_W | Number of bytes to read; zero is ignored |
| sdaIn | input | 1 | Sampled level of the bus data line |
| sclOut | output | 1 | Bus clock |
| sdaOut | output | 1 | Data value driven while enabled |
| sdaOe | output | 1 | Data output enable; low releases the line |
| rdByte | output | 8 | Last received byte |
| rdValid | output | 1 | One-cycle strobe marking a new rdByte |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| ackErr | output | 1 | Missing acknowledge seen in the last transaction |

## Verification
A bus-level memory model answers the block with known contents. Random transactions mix base addresses, counts from one to eight, and occasional refused acknowledges. Directed cases cover:
- a single byte, which separates the last-byte no-acknowledge from the between-bytes acknowledge;
- an address run that wraps past 0xFF, which separates the address increment from a plain echo;
- a refusal at each of the three transmitted bytes, which shows exactly where the sequence is cut short;
- a second start during a busy transaction and a zero-length request, which show that neither disturbs the bus.

// File: rtl/eeprom_rd_pkg.sv
`timescale 1ns/1ps
package eeprom_rd_pkg;

  typedef enum logic [1:0] {
    SDA_ONE,
    SDA_ZERO,
    SDA_TX,
    SDA_ACK
  } sdaSrc_e;

  typedef enum logic [1:0] {
    TXB_CTLW,
    TXB_ADDR,
    TXB_CTLR
  } txSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_MACK,
    ST_STOP
  } seqSt_e;

  typedef enum logic [1:0] {
    PH_CTLW,
    PH_ADDR,
    PH_CTLR
  } phase_e;

  typedef struct packed {
    logic    run;
    logic    sclLvl;
    logic    oeLvl;
    sdaSrc_e sdaSrc;
    logic    loadReq;
    logic    loadTx;
    txSel_e  txSel;
    logic    shiftTx;
    logic    sampleRx;
    logic    decCnt;
    logic    emitByte;
  } ctrlStrb_t;

endpackage

// File: rtl/eeprom_rd_dp.sv
`timescale 1ns/1ps
module eeprom_rd_dp
  import eeprom_rd_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int CNT_W = 8,
  parameter logic [6:0] DEV_SEL = 7'h50
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [7:0]       baseAddr,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             sdaIn,
  output logic             stepEnd,
  output logic             lastByte,
  output logic             sclOut,
  output logic             sdaOut,
  output logic             sdaOe,
  output logic [7:0]       rdByte,
  output logic             rdValid
);

  localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [TW-1:0] HALF_LAST = TW'(HALF_CYC - 1);
  localparam logic [7:0] CTL_WR = {DEV_SEL, 1'b0};
  localparam logic [7:0] CTL_RD = {DEV_SEL, 1'b1};

  logic [TW-1:0]    halfCnt;
  logic [7:0]       baseQ;
  logic [CNT_W-1:0] cntQ;
  logic [7:0]       txShift;
  logic [7:0]       rxShift;
  logic             sdaNext;

  // half-period timer: one step of the bus sequence per wrap
  always_ff @(posedge clk) begin
    if (!rstN || !strb.run) begin
      halfCnt <= '0;
    end else if (halfCnt == HALF_LAST) begin
      halfCnt <= '0;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  assign stepEnd  = strb.run && (halfCnt == HALF_LAST);
  assign lastByte = (cntQ == CNT_W'(1));

  // request latch and remaining-byte counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= '0;
    end else if (strb.loadReq) begin
      baseQ <= baseAddr;
      cntQ  <= byteCount;
    end else if (strb.decCnt) begin
      cntQ  <= cntQ - 1'b1;
    end
  end

  // transmit shifter, MSB first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strb.loadTx) begin
      case (strb.txSel)
        TXB_CTLW: txShift <= CTL_WR;
        TXB_ADDR: txShift <= baseQ;
        default:  txShift <= CTL_RD;
      endcase
    end else if (strb.shiftTx) begin
      txShift <= {txShift[6:0], 1'b0};
    end
  end

  // receive shifter and byte output
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      rdByte  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strb.sampleRx) begin
        rxShift <= {rxShift[6:0], sdaIn};
      end
      if (strb.emitByte) begin
        rdByte <= rxShift;
      end
      rdValid <= strb.emitByte;
    end
  end

  always_comb begin
    case (strb.sdaSrc)
      SDA_ZERO: sdaNext = 1'b0;
      SDA_TX:   sdaNext = txShift[7];
      SDA_ACK:  sdaNext = lastByte;
      default:  sdaNext = 1'b1;
    endcase
  end

  // registered pin drivers: all three move on the same edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclOut <= 1'b0;
      sdaOut <= 1'b1;
      sdaOe  <= 1'b0;
    end else begin
      sclOut <= strb.sclLvl;
      sdaOut <= sdaNext;
      sdaOe  <= strb.oeLvl;
    end
  end

endmodule

// File: rtl/eeprom_rd_ctrl.sv
`timescale 1ns/1ps
module eeprom_rd_ctrl
  import eeprom_rd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      reqZero,
  input  logic      sdaIn,
  input  logic      stepEnd,
  input  logic      lastByte,
  output ctrlStrb_t strb,
  output logic      done,
  output logic      ackErr
);

  seqSt_e     st;
  phase_e     phase;
  logic [1:0] stepIdx;
  logic [2:0] bitIdx;
  logic       nackSeen;
  logic       errFlag;
  logic [1:0] lastStep;
  logic       stepDone;
  logic       accept;
  logic       highStep;

  assign lastStep = (st == ST_START || st == ST_STOP) ? 2'd3 : 2'd2;
  assign stepDone = stepEnd && (stepIdx == lastStep);
  assign accept   = (st == ST_IDLE) && startReq && !reqZero;
  assign highStep = (stepIdx == 2'd1);

  // per-state pin levels and datapath strobes
  always_comb begin
    strb         = '0;
    strb.run     = (st != ST_IDLE);
    strb.sdaSrc  = SDA_ONE;
    strb.txSel   = TXB_CTLW;
    strb.loadReq = accept;
    case (st)
      ST_START: begin
        strb.oeLvl = 1'b1;
        case (stepIdx)
          2'd0: begin strb.sclLvl = 1'b0; strb.sdaSrc = SDA_ONE;  end
          2'd1: begin strb.sclLvl = 1'b1; strb.sdaSrc = SDA_ONE;  end
          2'd2: begin strb.sclLvl = 1'b1; strb.sdaSrc = SDA_ZERO; end
          default: begin strb.sclLvl = 1'b0; strb.sdaSrc = SDA_ZERO; end
        endcase
        strb.loadTx = stepDone;
        strb.txSel  = (phase == PH_CTLW) ? TXB_CTLW : TXB_CTLR;
      end
      ST_WBYTE: begin
        strb.sclLvl  = highStep;
        strb.oeLvl   = 1'b1;
        strb.sdaSrc  = SDA_TX;
        strb.shiftTx = stepDone && (bitIdx != 3'd7);
      end
      ST_WACK: begin
        strb.sclLvl = highStep;
        strb.loadTx = stepDone && !nackSeen && (phase == PH_CTLW);
        strb.txSel  = TXB_ADDR;
      end
      ST_RBYTE: begin
        strb.sclLvl   = highStep;
        strb.sampleRx = stepEnd && highStep;
        strb.emitByte = stepDone && (bitIdx == 3'd7);
      end
      ST_MACK: begin
        strb.sclLvl = highStep;
        strb.oeLvl  = 1'b1;
        strb.sdaSrc = SDA_ACK;
        strb.decCnt = stepDone;
      end
      ST_STOP: begin
        case (stepIdx)
          2'd0: begin strb.sclLvl = 1'b0; strb.oeLvl = 1'b1; strb.sdaSrc = SDA_ZERO; end
          2'd1: begin strb.sclLvl = 1'b1; strb.oeLvl = 1'b1; strb.sdaSrc = SDA_ZERO; end
          2'd2: begin strb.sclLvl = 1'b1; strb.oeLvl = 1'b0; strb.sdaSrc = SDA_ONE;  end
          default: begin strb.sclLvl = 1'b0; strb.oeLvl = 1'b0; strb.sdaSrc = SDA_ONE; end
        endcase
      end
      default: begin
        strb.sclLvl = 1'b0;
        strb.oeLvl  = 1'b0;
      end
    endcase
  end

  // sequence register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      phase    <= PH_CTLW;
      stepIdx  <= '0;
      bitIdx   <= '0;
      nackSeen <= 1'b0;
      errFlag  <= 1'b0;
      done     <= 1'b0;
      ackErr   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        st      <= ST_START;
        phase   <= PH_CTLW;
        stepIdx <= '0;
        bitIdx  <= '0;
        errFlag <= 1'b0;
        ackErr  <= 1'b0;
      end else if (stepEnd) begin
        if (st == ST_WACK && highStep) begin
          nackSeen <= sdaIn;
        end
        if (!stepDone) begin
          stepIdx <= stepIdx + 1'b1;
        end else begin
          stepIdx <= '0;
          case (st)
            ST_START: begin
              st     <= ST_WBYTE;
              bitIdx <= '0;
            end
            ST_WBYTE: begin
              if (bitIdx == 3'd7) st <= ST_WACK;
              else bitIdx <= bitIdx + 1'b1;
            end
            ST_WACK: begin
              bitIdx <= '0;
              if (nackSeen) begin
                errFlag <= 1'b1;
                st      <= ST_STOP;
              end else begin
                case (phase)
                  PH_CTLW: begin phase <= PH_ADDR; st <= ST_WBYTE; end
                  PH_ADDR: begin phase <= PH_CTLR; st <= ST_START; end
                  default: st <= ST_RBYTE;
                endcase
              end
            end
            ST_RBYTE: begin
              if (bitIdx == 3'd7) st <= ST_MACK;
              else bitIdx <= bitIdx + 1'b1;
            end
            ST_MACK: begin
              bitIdx <= '0;
              st     <= lastByte ? ST_STOP : ST_RBYTE;
            end
            ST_STOP: begin
              st     <= ST_IDLE;
              done   <= 1'b1;
              ackErr <= errFlag;
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/eeprom_rd_seq.sv
`timescale 1ns/1ps
module eeprom_rd_seq
  import eeprom_rd_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int CNT_W = 8,
  parameter logic [6:0] DEV_SEL = 7'h50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [7:0]       baseAddr,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             sdaIn,
  output logic             sclOut,
  output logic             sdaOut,
  output logic             sdaOe,
  output logic [7:0]       rdByte,
  output logic             rdValid,
  output logic             done,
  output logic             ackErr
);

  ctrlStrb_t strb;
  logic      stepEnd;
  logic      lastByte;
  logic      reqZero;

  assign reqZero = (byteCount == '0);

  eeprom_rd_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .reqZero  (reqZero),
    .sdaIn    (sdaIn),
    .stepEnd  (stepEnd),
    .lastByte (lastByte),
    .strb     (strb),
    .done     (done),
    .ackErr   (ackErr)
  );

  eeprom_rd_dp #(
    .HALF_CYC (HALF_CYC),
    .CNT_W    (CNT_W),
    .DEV_SEL  (DEV_SEL)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .baseAddr  (baseAddr),
    .byteCount (byteCount),
    .sdaIn     (sdaIn),
    .stepEnd   (stepEnd),
    .lastByte  (lastByte),
    .sclOut    (sclOut),
    .sdaOut    (sdaOut),
    .sdaOe     (sdaOe),
    .rdByte    (rdByte),
    .rdValid   (rdValid)
  );

endmodule

// File: rtl/eeprom_rd_chk.sv
`timescale 1ns/1ps
module eeprom_rd_chk #(
  parameter int HALF_CYC = 4
) (
  input logic clk,
  input logic rstN,
  input logic sclOut,
  input logic sdaOut,
  input logic sdaOe,
  input logic rdValid,
  input logic done,
  input logic ackErr
);

  logic [15:0] hiLen;

  always_ff @(posedge clk) begin
    if (!rstN) hiLen <= '0;
    else if (sclOut) hiLen <= hiLen + 1'b1;
    else hiLen <= '0;
  end

  AST_EDGE_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclOut) || $fell(sclOut)) |-> ($stable(sdaOut) && $stable(sdaOe))); // R1

  AST_START_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    (sclOut && $past(sclOut) && $fell(sdaOut)) |-> sdaOe); // R2

  AST_DONE_BUS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!sclOut && !sdaOe)); // R3

  AST_SCL_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclOut) |-> ((hiLen == 16'(HALF_CYC)) || (hiLen == 16'(2 * HALF_CYC)))); // R5

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackErr) |-> done); // R9

endmodule

bind eeprom_rd_seq eeprom_rd_chk #(.HALF_CYC(HALF_CYC)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .sclOut  (sclOut),
  .sdaOut  (sdaOut),
  .sdaOe   (sdaOe),
  .rdValid (rdValid),
  .done    (done),
  .ackErr  (ackErr)
);

// File: tb/tb_eeprom_rd_seq.sv
`timescale 1ns/1ps
module tb_eeprom_rd_seq;

  localparam int HALF = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [7:0] baseAddr = '0;
  logic [CW-1:0] byteCount = '0;
  logic sdaIn;
  logic sclOut, sdaOut, sdaOe, rdValid, done, ackErr;
  logic [7:0] rdByte;

  always #2.5 clk = ~clk;

  eeprom_rd_seq #(.HALF_CYC(HALF), .CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .baseAddr(baseAddr),
    .byteCount(byteCount), .sdaIn(sdaIn), .sclOut(sclOut), .sdaOut(sdaOut),
    .sdaOe(sdaOe), .rdByte(rdByte), .rdValid(rdValid), .done(done), .ackErr(ackErr)
  );

  // ---------------- memory model and bus monitor ----------------
  localparam int M_IDLE = 0, M_RXB = 1, M_ACK = 2, M_TXB = 3, M_MACK = 4;

  logic slvDrv;
  assign sdaIn = slvDrv;

  int nRecv = 0, nGot = 0, nMack = 0, nStart = 0, nStop = 0, nDone = 0;
  int edgeViol = 0, badHi = 0, nackIdx = -1;
  logic lastErr = 1'b0;
  logic [7:0] recvLog [0:511];
  logic [7:0] gotLog [0:511];
  logic mackLog [0:511];

  function automatic logic [7:0] memByte(input logic [7:0] a);
    return ((a * 8'd29) ^ 8'h5A) + {a[3:0], a[7:4]};
  endfunction

  function automatic logic busLine(input logic oe, input logic dOut, input logic drv);
    return (oe ? dOut : 1'b1) & drv;
  endfunction

  int mode = M_IDLE, bitCnt = 0, hiRun = 0, sinceStart = 0;
  logic prevScl = 1'b0, prevLine = 1'b1, nacked = 1'b0;
  logic [7:0] shreg = '0, lastRx = '0, ptr = '0;

  always @(negedge clk) begin
    logic ln;
    if (!rstN) begin
      slvDrv <= 1'b1;
      mode = M_IDLE;
      prevScl = 1'b0;
      prevLine = 1'b1;
      hiRun = 0;
    end else begin
      ln = busLine(sdaOe, sdaOut, slvDrv);
      if (rdValid) begin gotLog[nGot & 511] = rdByte; nGot++; end
      if (done) begin nDone++; lastErr = ackErr; end
      if (sclOut) hiRun++;
      else begin
        if (prevScl && hiRun != HALF && hiRun != 2 * HALF) badHi++;
        hiRun = 0;
      end
      if ((sclOut != prevScl) && (ln != prevLine)) edgeViol++;
      if (sclOut && prevScl && prevLine && !ln) begin
        nStart++; mode = M_RXB; bitCnt = 0; sinceStart = 0; slvDrv <= 1'b1;
      end else if (sclOut && prevScl && !prevLine && ln) begin
        nStop++; mode = M_IDLE; slvDrv <= 1'b1;
      end else if (sclOut && !prevScl) begin
        if (mode == M_RXB) begin shreg = {shreg[6:0], ln}; bitCnt++; end
        else if (mode == M_TXB) bitCnt++;
        else if (mode == M_MACK) begin mackLog[nMack & 511] = ln; nMack++; end
      end else if (!sclOut && prevScl) begin
        case (mode)
          M_RXB: if (bitCnt == 8) begin
            recvLog[nRecv & 511] = shreg;
            lastRx = shreg;
            nacked = (nackIdx == nRecv);
            nRecv++;
            sinceStart++;
            slvDrv <= nacked;
            mode = M_ACK;
          end
          M_ACK: begin
            slvDrv <= 1'b1;
            if (nacked) mode = M_IDLE;
            else if (sinceStart == 1 && lastRx[0]) begin
              mode = M_TXB; bitCnt = 0; slvDrv <= memByte(ptr)[7];
            end else begin
              if (sinceStart == 2) ptr = lastRx;
              mode = M_RXB; bitCnt = 0;
            end
          end
          M_TXB: begin
            if (bitCnt == 8) begin slvDrv <= 1'b1; mode = M_MACK; end
            else slvDrv <= memByte(ptr)[7 - bitCnt];
          end
          M_MACK: begin
            ptr = ptr + 8'd1;
            if (mackLog[(nMack - 1) & 511] == 1'b0) begin
              mode = M_TXB; bitCnt = 0; slvDrv <= memByte(ptr)[7];
            end else begin
              mode = M_IDLE; slvDrv <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      prevScl = sclOut;
      prevLine = ln;
    end
  end

  // ---------------- checking ----------------
  int nChk = 0, nBad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runTx(input logic [7:0] base, input int cnt, input int nackK, input bit busyProbe);
    int sRecv, sGot, sMack, sStart, sStop, sDone, sEdge, sHi, t, expBytes;
    bit expErr;
    sRecv = nRecv; sGot = nGot; sMack = nMack; sStart = nStart;
    sStop = nStop; sDone = nDone; sEdge = edgeViol; sHi = badHi;
    nackIdx = (nackK < 0) ? -1 : sRecv + nackK;
    expErr = (nackK >= 0);
    expBytes = expErr ? 0 : cnt;
    @(negedge clk);
    baseAddr = base; byteCount = CW'(cnt); startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (2) @(negedge clk);
    chk(ackErr == 1'b0, "R9 ackErr cleared on start", ackErr, 0);
    if (busyProbe) begin
      repeat (40) @(negedge clk);
      baseAddr = ~base; byteCount = CW'(3); startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
    end
    t = 0;
    while (nDone == sDone && t < 30000) begin @(negedge clk); t++; end
    repeat (60) @(negedge clk);
    chk(nDone == sDone + 1, "R9 exactly one done", nDone - sDone, 1);
    if (busyProbe) chk(nDone == sDone + 1, "R10 busy start ignored", nDone - sDone, 1);
    chk(lastErr == expErr, "R8 ackErr value", lastErr, expErr);
    chk(nStop - sStop == 1, "R3 one stop", nStop - sStop, 1);
    chk(!sclOut && !sdaOe, "R3 bus idle after stop", {sclOut, sdaOe}, 0);
    chk(nStart - sStart == ((nackK == 0 || nackK == 1) ? 1 : 2), "R2 start count",
        nStart - sStart, (nackK == 0 || nackK == 1) ? 1 : 2);
    chk(recvLog[sRecv & 511] == 8'hA0, "R4 write control", recvLog[sRecv & 511], 8'hA0);
    if (nackK < 0 || nackK >= 1)
      chk(recvLog[(sRecv + 1) & 511] == base, "R4 word address", recvLog[(sRecv + 1) & 511], base);
    if (nackK < 0 || nackK >= 2)
      chk(recvLog[(sRecv + 2) & 511] == 8'hA1, "R4 read control", recvLog[(sRecv + 2) & 511], 8'hA1);
    chk(nGot - sGot == expBytes, "R7 R8 byte count", nGot - sGot, expBytes);
    for (int i = 0; i < expBytes; i++) begin
      logic [7:0] e;
      e = memByte(base + 8'(i));
      chk(gotLog[(sGot + i) & 511] == e, "R7 R4 byte value", gotLog[(sGot + i) & 511], e);
    end
    chk(nMack - sMack == expBytes, "R6 master ack count", nMack - sMack, expBytes);
    for (int i = 0; i < expBytes; i++) begin
      logic ev;
      ev = (i == expBytes - 1);
      chk(mackLog[(sMack + i) & 511] == ev, "R6 master ack level", mackLog[(sMack + i) & 511], ev);
    end
    chk(edgeViol == sEdge, "R1 data change at clock edge", edgeViol - sEdge, 0);
    chk(badHi == sHi, "R5 clock high width", badHi - sHi, 0);
    nackIdx = -1;
  endtask

  task automatic runAll();
    int sDone, sStart;
    void'($urandom(32'd24680));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(sclOut == 1'b0 && sdaOe == 1'b0 && sdaOut == 1'b1, "R3 reset idle bus",
        {sclOut, sdaOe, sdaOut}, 3'b001);
    chk(done == 1'b0 && rdValid == 1'b0 && ackErr == 1'b0, "R9 reset flags",
        {done, rdValid, ackErr}, 0);
    // R10: zero length request
    sDone = nDone; sStart = nStart;
    baseAddr = 8'h83; byteCount = '0; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (150) @(negedge clk);
    chk(nDone == sDone, "R10 zero count no done", nDone - sDone, 0);
    chk(nStart == sStart && !sdaOe, "R10 zero count no bus activity", nStart - sStart, 0);
    // directed
    runTx(8'h83, 6, -1, 1'b0);
    runTx(8'hF8, 6, -1, 1'b0);
    runTx(8'hFE, 4, -1, 1'b0);
    runTx(8'h42, 1, -1, 1'b0);
    runTx(8'h99, 3, 0, 1'b0);
    runTx(8'hAF, 3, 1, 1'b0);
    runTx(8'h10, 3, 2, 1'b0);
    runTx(8'h20, 5, -1, 1'b0);
    runTx(8'h55, 4, -1, 1'b1);
    // random
    for (int k = 0; k < 16; k++) begin
      int c, n;
      c = 1 + int'($urandom % 8);
      n = (($urandom % 5) == 0) ? int'($urandom % 3) : -1;
      runTx(8'($urandom), c, n, 1'b0);
    end
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule